// File: doc/BRIEF.md
# Two-Way Set-Associative Address Translator

This block turns a 20-bit virtual address into an 18-bit physical address with 1 KiB pages. A 16-entry translation cache holds recent page mappings, arranged as 8 sets of 2 ways. The 10-bit virtual page number is split into two fields. Its low 3 bits pick the set, and its upper 7 bits are compared against the stored tags. The 10-bit page offset passes through unchanged.

When the cache holds no matching entry, the block reads one page table entry through a ready/valid memory port. The entry address is the page table base plus the virtual page number. A valid entry completes the translation and is written into the cache. An invalid entry reports a page fault.

A separate preload port lets an external agent install a mapping. A global invalidate input clears every entry at once. Only one translation is in flight at a time.

Top module: `tlb_xlate`

## Requirements
- R1: The low 10 bits of `paddr` always equal the low 10 bits of the accepted virtual address. The upper 8 bits of `paddr` are the physical page number.
- R2: A request hits when the set selected by vaddr[12:10] holds a valid entry whose tag equals vaddr[19:13]. A hit raises `done` with `hit`=1, `fault`=0 and `paddr`={stored PPN, offset} exactly one cycle after acceptance, and issues no page table access.
- R3: On a miss, `pt_req_valid` rises with `pt_req_addr` = `ptbr` + zero-extended VPN (16-bit, wrapping). The request stays asserted, with a stable address, until `pt_req_ready` is seen.
- R4: Page table entries are 9 bits: bit 8 is the valid flag and bits 7:0 are the PPN. A valid entry completes the request with `hit`=0, `fault`=0 and `paddr`={PPN, offset}, and installs the mapping. A later request to the same page then hits.
- R5: An entry with bit 8 clear completes the request with `fault`=1, `hit`=0 and `paddr`=0, and installs nothing. A repeat of the same page misses again.
- R6: A write into a set replaces a way holding the same tag if there is one. Otherwise it takes an invalid way, trying way 0 first. If neither applies, it takes the least recently used way. Hits and writes both mark their way as most recently used. A tag never occupies both ways of a set.
- R7: A one-cycle pulse on `inv_all` invalidates every entry by the next cycle.
- R8: `req_ready` is high only while no translation is in flight. Each accepted request produces exactly one `done` pulse of one cycle.
- R9: A `fill_en` pulse installs `fill_vpn`→`fill_ppn` using the R6 way choice. A later request to that page hits.
- R10: After reset all entries are invalid, `req_ready`=1, and `done`=0 and `pt_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_vaddr | input | 20 | Virtual address to translate |
| ptbr | input | 16 | Page table base, sampled when a request is accepted |
| fill_en | input | 1 | Preload one mapping |
| fill_vpn | input | 10 | Virtual page number to preload |
| fill_ppn | input | 8 | Physical page number to preload |
| inv_all | input | 1 | Invalidate all entries |
| done | output | 1 | One-cycle completion strobe |
| hit | output | 1 | Completed translation came from the cache |
| fault | output | 1 | Completed translation found an invalid page table entry |
| paddr | output | 18 | Physical address (zero on fault) |
| pt_req_valid | output | 1 | Page table read request |
| pt_req_ready | input | 1 | Memory accepts the read request |
| pt_req_addr | output | 16 | Page table entry address |
| pt_rsp_valid | input | 1 | Page table entry returned |
| pt_rsp_pte | input | 9 | Returned entry: bit 8 valid, bits 7:0 PPN |

## Verification
Several properties are checked on every cycle:
- no set ever holds one tag in both ways;
- a stalled page table request keeps its address;
- a fault always carries a zero address and no hit;
- a hit completion always follows an acceptance by one cycle;
- the offset passes through on every good completion;
- invalidation empties the array.

Replacement order is visible only through the directed scenarios: the least recently used way is evicted after a mix of hits and preloads. The same holds for the refusal to cache a faulting entry, and for the exact physical addresses of the worked translations.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VA_W   = 20;
    localparam int PA_W   = 18;
    localparam int OFF_W  = 10;
    localparam int SET_W  = 3;
    localparam int PT_AW  = 16;
    localparam int WAYS   = 2;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int TAG_W  = VPN_W - SET_W;
    localparam int SETS   = 1 << SET_W;
    localparam int PTE_W  = PPN_W + 1;

    typedef struct packed {
        logic             vld;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [SET_W-1:0] idx;
    } vpn_t;

    typedef struct packed {
        vpn_t             vpn;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_REQ  = 2'd1,
        W_WAIT = 2'd2
    } walk_st_e;

    function automatic logic [PT_AW-1:0] pte_addr(input logic [PT_AW-1:0] base,
                                                   input vpn_t v);
        return base + PT_AW'(v);
    endfunction
endpackage

// File: rtl/tlb_array.sv
module tlb_array
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inv_all,
    input  logic [SET_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_way,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_idx,
    input  logic             touch_way,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn
);
    logic [SETS-1:0][WAYS-1:0] vld;
    logic [TAG_W-1:0]          tag_q [SETS][WAYS];
    logic [PPN_W-1:0]          ppn_q [SETS][WAYS];
    logic [SETS-1:0]           lru;   // way to evict next

    logic [WAYS-1:0] way_hit;
    logic [WAYS-1:0] way_same;
    logic            victim;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_hit[w]  = vld[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
        assign way_same[w] = vld[wr_idx][w] && (tag_q[wr_idx][w] == wr_tag);
    end

    assign lk_hit = |way_hit;
    assign lk_way = way_hit[1];
    assign lk_ppn = way_hit[1] ? ppn_q[lk_idx][1] : ppn_q[lk_idx][0];

    always_comb begin
        if (way_same[0])             victim = 1'b0;
        else if (way_same[1])        victim = 1'b1;
        else if (!vld[wr_idx][0])    victim = 1'b0;
        else if (!vld[wr_idx][1])    victim = 1'b1;
        else                         victim = lru[wr_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            lru <= '0;
        end else begin
            if (touch_en)
                lru[touch_idx] <= ~touch_way;
            if (wr_en) begin
                vld[wr_idx][victim] <= 1'b1;
                lru[wr_idx]         <= ~victim;
            end
            if (inv_all)
                vld <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][victim] <= wr_tag;
            ppn_q[wr_idx][victim] <= wr_ppn;
        end
    end

    // R7: invalidate empties every set on the following cycle
    p_inv_clears_r7: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (vld == '0));

    // R9: a write without invalidate leaves an occupied set
    p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inv_all) |=> (vld[$past(wr_idx)] != '0));

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        // R6: a tag never sits in both ways of a set
        p_no_dup_r6: assert property (@(posedge clk) disable iff (rst)
            !(vld[s] == 2'b11 && tag_q[s][0] == tag_q[s][1]));
    end
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PT_AW-1:0] ptbr,
    output logic             req_ready,
    output logic [SET_W-1:0] lk_idx,
    output logic [TAG_W-1:0] lk_tag,
    input  logic             lk_hit,
    input  logic             lk_way,
    input  logic [PPN_W-1:0] lk_ppn,
    output logic             touch_en,
    output logic [SET_W-1:0] touch_idx,
    output logic             touch_way,
    output logic             refill_en,
    output logic [SET_W-1:0] refill_idx,
    output logic [TAG_W-1:0] refill_tag,
    output logic [PPN_W-1:0] refill_ppn,
    output logic             pt_req_valid,
    input  logic             pt_req_ready,
    output logic [PT_AW-1:0] pt_req_addr,
    input  logic             pt_rsp_valid,
    input  logic [PTE_W-1:0] pt_rsp_pte,
    output logic             done,
    output logic             hit,
    output logic             fault,
    output logic [PA_W-1:0]  paddr
);
    walk_st_e st;
    vaddr_t   va_in;
    vaddr_t   va_q;
    pte_t     pte;
    logic     acc;
    logic     rsp_take;

    always_comb begin
        va_in      = vaddr_t'(req_vaddr);
        pte        = pte_t'(pt_rsp_pte);
        acc        = (st == W_IDLE) && req_valid;
        rsp_take   = (st == W_WAIT) && pt_rsp_valid;
        lk_idx     = va_in.vpn.idx;
        lk_tag     = va_in.vpn.tag;
        touch_en   = acc && lk_hit;
        touch_idx  = va_in.vpn.idx;
        touch_way  = lk_way;
        refill_en  = rsp_take && pte.vld;
        refill_idx = va_q.vpn.idx;
        refill_tag = va_q.vpn.tag;
        refill_ppn = pte.ppn;
    end

    assign req_ready    = (st == W_IDLE);
    assign pt_req_valid = (st == W_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= W_IDLE;
            va_q        <= '0;
            pt_req_addr <= '0;
            done        <= 1'b0;
            hit         <= 1'b0;
            fault       <= 1'b0;
            paddr       <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                W_IDLE: if (acc) begin
                    va_q <= va_in;
                    if (lk_hit) begin
                        done  <= 1'b1;
                        hit   <= 1'b1;
                        fault <= 1'b0;
                        paddr <= {lk_ppn, va_in.off};
                    end else begin
                        pt_req_addr <= pte_addr(ptbr, va_in.vpn);
                        st          <= W_REQ;
                    end
                end
                W_REQ: if (pt_req_ready) st <= W_WAIT;
                W_WAIT: if (rsp_take) begin
                    done  <= 1'b1;
                    hit   <= 1'b0;
                    fault <= ~pte.vld;
                    paddr <= pte.vld ? {pte.ppn, va_q.off} : '0;
                    st    <= W_IDLE;
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    // R3: a stalled table request holds its address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pt_req_valid && !pt_req_ready) |=> (pt_req_valid && $stable(pt_req_addr)));

    // R5: a fault never carries an address or a hit
    p_fault_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (paddr == '0 && !hit));

    // R2: a cache hit completes one cycle after acceptance
    p_hit_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (done && hit) |-> $past(req_valid && req_ready));

    // R8: a walk completion only follows a returned entry
    p_walk_done_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> $past(st == W_WAIT && pt_rsp_valid));

    // R1: offset passes through on every good completion
    p_offset_r1: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (paddr[OFF_W-1:0] == va_q.off));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [PT_AW-1:0] ptbr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             inv_all,
    output logic             done,
    output logic             hit,
    output logic             fault,
    output logic [PA_W-1:0]  paddr,
    output logic             pt_req_valid,
    input  logic             pt_req_ready,
    output logic [PT_AW-1:0] pt_req_addr,
    input  logic             pt_rsp_valid,
    input  logic [PTE_W-1:0] pt_rsp_pte
);
    logic [SET_W-1:0] lk_idx, touch_idx, refill_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, refill_tag, wr_tag;
    logic [PPN_W-1:0] lk_ppn, refill_ppn, wr_ppn;
    logic             lk_hit, lk_way, touch_en, touch_way, refill_en, wr_en;
    vpn_t             fill_v;

    // refill from the walker takes precedence over an external preload
    always_comb begin
        fill_v = vpn_t'(fill_vpn);
        wr_en  = refill_en | fill_en;
        wr_idx = refill_en ? refill_idx : fill_v.idx;
        wr_tag = refill_en ? refill_tag : fill_v.tag;
        wr_ppn = refill_en ? refill_ppn : fill_ppn;
    end

    tlb_walker u_walk (
        .clk, .rst, .req_valid, .req_vaddr, .ptbr, .req_ready,
        .lk_idx, .lk_tag, .lk_hit, .lk_way, .lk_ppn,
        .touch_en, .touch_idx, .touch_way,
        .refill_en, .refill_idx, .refill_tag, .refill_ppn,
        .pt_req_valid, .pt_req_ready, .pt_req_addr, .pt_rsp_valid, .pt_rsp_pte,
        .done, .hit, .fault, .paddr
    );

    tlb_array u_arr (
        .clk, .rst, .inv_all,
        .lk_idx, .lk_tag, .lk_hit, .lk_way, .lk_ppn,
        .touch_en, .touch_idx, .touch_way,
        .wr_en, .wr_idx, .wr_tag, .wr_ppn
    );
endmodule

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vaddr = '0;
    logic [15:0] ptbr = 16'h0100;
    logic        fill_en = 1'b0;
    logic [9:0]  fill_vpn = '0;
    logic [7:0]  fill_ppn = '0;
    logic        inv_all = 1'b0;
    logic        done, hit, fault;
    logic [17:0] paddr;
    logic        pt_req_valid;
    logic        pt_req_ready = 1'b0;
    logic [15:0] pt_req_addr;
    logic        pt_rsp_valid = 1'b0;
    logic [8:0]  pt_rsp_pte = '0;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    tlb_xlate u_tlb_xlate (
        .clk, .rst, .req_valid, .req_ready, .req_vaddr, .ptbr,
        .fill_en, .fill_vpn, .fill_ppn, .inv_all,
        .done, .hit, .fault, .paddr,
        .pt_req_valid, .pt_req_ready, .pt_req_addr, .pt_rsp_valid, .pt_rsp_pte
    );

    // page table memory model
    logic [8:0]  ptmem [logic [15:0]];
    int          stall_cfg = 0;
    int          lat_cfg = 1;
    int          stall_cnt = 0;
    int          rsp_cnt = 0;
    bit          pending = 0;
    logic [15:0] m_addr = '0;
    int          req_cnt = 0;
    logic [15:0] last_addr = '0;

    always @(negedge clk) begin
        pt_rsp_valid = 1'b0;
        if (pending) begin
            if (rsp_cnt == 0) begin
                pt_rsp_valid = 1'b1;
                pt_rsp_pte   = ptmem.exists(m_addr) ? ptmem[m_addr] : 9'h000;
                pending      = 0;
            end else begin
                rsp_cnt--;
            end
        end
        if (pt_req_ready) begin
            pt_req_ready = 1'b0;
            pending      = 1;
            rsp_cnt      = lat_cfg;
        end else if (pt_req_valid && !rst) begin
            if (stall_cnt < stall_cfg) begin
                stall_cnt++;
            end else begin
                stall_cnt    = 0;
                pt_req_ready = 1'b1;
                m_addr       = pt_req_addr;
                last_addr    = pt_req_addr;
                req_cnt++;
            end
        end
    end

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic xlate(input logic [19:0] va, output int cyc, output int preqs);
        int r0;
        r0 = req_cnt;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        preqs = req_cnt - r0;
    endtask

    task automatic fill(input logic [9:0] vpn, input logic [7:0] ppn);
        @(negedge clk);
        fill_en  = 1'b1;
        fill_vpn = vpn;
        fill_ppn = ppn;
        @(negedge clk);
        fill_en  = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10", "req_ready", req_ready, 1);
        chk("R10", "done", done, 0);
        chk("R10", "pt_req_valid", pt_req_valid, 0);
    endtask

    task automatic t_walk_refill;
        int c, p;
        ptmem[16'h011E] = 9'h157;
        xlate(20'h078E6, c, p);
        chk("R4", "miss hit flag", hit, 0);
        chk("R4", "miss fault flag", fault, 0);
        chk("R4", "miss paddr", paddr, 18'h15CE6);
        chk("R3", "table address", last_addr, 16'h011E);
        chk("R3", "one table read", p, 1);
        @(negedge clk);
        chk("R8", "done single pulse", done, 0);
        xlate(20'h078E6, c, p);
        chk("R4", "refilled page hits", hit, 1);
        chk("R2", "hit latency", c, 1);
        chk("R2", "no table read on hit", p, 0);
    endtask

    task automatic t_preload_hit;
        int c, p;
        fill(10'h012, 8'h68);
        xlate(20'h04AA4, c, p);
        chk("R9", "preload hit", hit, 1);
        chk("R2", "hit paddr", paddr, 18'h1A2A4);
        chk("R2", "hit latency", c, 1);
        chk("R2", "no table read", p, 0);
    endtask

    task automatic t_fault;
        int c, p;
        ptmem[16'h0155] = 9'h0AB;
        xlate(20'h15400, c, p);
        chk("R5", "fault flag", fault, 1);
        chk("R5", "fault paddr", paddr, 0);
        chk("R5", "fault hit flag", hit, 0);
        xlate(20'h15400, c, p);
        chk("R5", "fault not cached", p, 1);
        chk("R5", "repeat fault", fault, 1);
    endtask

    task automatic t_stall;
        int cyc;
        bit bad;
        ptmem[16'h0123] = 9'h1C3;
        stall_cfg = 3;
        lat_cfg   = 2;
        bad       = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = 20'h08C01;   // vpn 0x023
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            if (req_ready) bad = 1;
            if (pt_req_valid && pt_req_addr !== 16'h0123) bad = 1;
            @(negedge clk);
            cyc++;
        end
        chk("R8", "busy while walking", bad, 0);
        chk("R3", "stalled walk completes", paddr, 18'h30C01);
        chk("R1", "offset through", paddr[9:0], 10'h001);
        stall_cfg = 0;
        lat_cfg   = 1;
    endtask

    task automatic t_lru;
        int c, p;
        fill(10'h009, 8'h11);   // set 1 way 0
        fill(10'h011, 8'h22);   // set 1 way 1
        xlate(20'h02555, c, p); // touch A
        chk("R6", "A hit", hit, 1);
        chk("R6", "A paddr", paddr, 18'h04555);
        fill(10'h019, 8'h33);   // evicts B
        xlate(20'h067FF, c, p);
        chk("R6", "C hit", hit, 1);
        chk("R1", "C paddr", paddr, 18'h0CFFF);
        ptmem[16'h0111] = 9'h144;
        xlate(20'h04400, c, p);
        chk("R6", "B evicted", p, 1);
        chk("R6", "B paddr", paddr, 18'h11000);
        ptmem[16'h0109] = 9'h111;
        xlate(20'h02400, c, p);
        chk("R6", "A evicted by refill", p, 1);
        xlate(20'h04401, c, p);
        chk("R6", "B still present", p, 0);
    endtask

    task automatic t_invalidate;
        int c, p;
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        ptmem[16'h0112] = 9'h168;
        xlate(20'h04AA4, c, p);
        chk("R7", "miss after invalidate", p, 1);
        chk("R7", "paddr after walk", paddr, 18'h1A2A4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_walk_refill();
        t_preload_hit();
        t_fault();
        t_stall();
        t_lru();
        t_invalidate();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule